// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through cache and the next memory level. It takes processor stores (address and data) into a small circular queue, so the processor does not wait for memory on each store. Stores tend to come in bursts, so the queue has several entries. The queue drains to memory in arrival order, one entry per memory acknowledge, through a plain request/acknowledge write port.

Loads are not held behind queued stores. A load whose address matches no queued entry goes straight to the memory read port in the same cycle, even when stores are still waiting. A load that matches a queued entry is served from the queue instead, so it never sees stale memory contents. When more than one entry holds the load's address, the most recently queued value is returned. A full flag tells the processor to hold a store only when every slot is taken.

Top module: `wr_post_buffer`

## Requirements
- R1: After a synchronous reset the queue is empty: `cpu_wr_full` is 0 and `mem_wr_req` is 0.
- R2: A store with `cpu_wr_valid`=1 is taken at the clock edge whenever `cpu_wr_full` is 0. `cpu_wr_full` is 1 exactly when DEPTH entries are held. A store offered while full is dropped: after the queue drains, only the DEPTH earlier entries come out.
- R3: `mem_wr_req` is 1 whenever at least one entry is held. `mem_wr_addr`/`mem_wr_data` show the oldest entry and stay unchanged until `mem_wr_ack`=1. Entries leave in arrival order, one per edge with `mem_wr_ack`=1.
- R4: A store and a drain at the same edge both take effect, and the occupancy is unchanged.
- R5: A load (`cpu_rd_valid`=1) whose address matches a held entry gives `rd_fwd_hit`=1 and that entry's data on `rd_fwd_data` in the same cycle, with `mem_rd_req`=0. A store offered in the same cycle is seen by loads only from the next cycle on.
- R6: When several held entries match the load address, `rd_fwd_data` is the data of the most recently queued one.
- R7: A load that matches no held entry gives `rd_fwd_hit`=0 and `mem_rd_req`=1 with `mem_rd_addr` equal to the load address in the same cycle, even while stores are queued.
- R8: With the queue empty, every load misses the queue and goes to memory.
- R9: Once an entry has drained (acknowledged), a load to its address, with no other copy queued, misses the queue and goes to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr_valid | input | 1 | Processor store request |
| cpu_wr_addr | input | ADDR_W | Store address |
| cpu_wr_data | input | DATA_W | Store data |
| cpu_wr_full | output | 1 | All slots held; processor must hold its store |
| cpu_rd_valid | input | 1 | Processor load request |
| cpu_rd_addr | input | ADDR_W | Load address |
| rd_fwd_hit | output | 1 | Load served from the queue |
| rd_fwd_data | output | DATA_W | Forwarded data, meaningful when `rd_fwd_hit`=1 |
| mem_rd_req | output | 1 | Load sent to memory (queue miss) |
| mem_rd_addr | output | ADDR_W | Memory load address |
| mem_wr_req | output | 1 | Oldest queued store offered to memory |
| mem_wr_addr | output | ADDR_W | Address of the oldest entry |
| mem_wr_data | output | DATA_W | Data of the oldest entry |
| mem_wr_ack | input | 1 | Memory takes the offered store at this edge |

## Verification
Random traffic uses addresses from a set of eight, so loads often hit one, several or no queued entries. This separates oldest-match from newest-match selection and forwarding from bypass. Random acknowledge gaps separate occupancy bookkeeping errors from ordering errors, and they make stores and drains meet at the same edge. Directed sequences fill the queue and then push one more store, write one address twice, load from an empty queue, and load an address right after it drains. Each of these targets a boundary that random traffic seldom reaches.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    parameter int unsigned ADDR_W = 16;
    parameter int unsigned DATA_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wpb_entry_t;

    // position of the entry that is `off` places younger than the slot at `base`
    function automatic int unsigned wpb_wrap(input int unsigned base,
                                             input int unsigned off,
                                             input int unsigned depth);
        int unsigned s;
        s = base + off;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/wpb_ptrs.sv
module wpb_ptrs #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full  = (count == CAP);
    assign empty = (count == '0);

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);

    p_same_count_r4: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> (count == $past(count)));

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (empty && !push) |=> empty);

endmodule

// File: rtl/wpb_store.sv
module wpb_store
    import wpb_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [PTR_W-1:0]             wr_ptr,
    input  wpb_entry_t                   wr_entry,
    input  logic                         pop,
    input  logic [PTR_W-1:0]             rd_ptr,
    output wpb_entry_t [DEPTH-1:0]       slots,
    output logic       [DEPTH-1:0]       valid
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic load_here;
        logic drop_here;
        assign load_here = push && (wr_ptr == PTR_W'(g));
        assign drop_here = pop  && (rd_ptr == PTR_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid[g] <= 1'b0;
                slots[g] <= '0;
            end else begin
                if (load_here) begin
                    slots[g] <= wr_entry;
                    valid[g] <= 1'b1;
                end else if (drop_here) begin
                    valid[g] <= 1'b0;
                end
            end
        end

        p_slot_kept_r3: assert property (@(posedge clk) disable iff (rst)
            (valid[g] && !drop_here) |=> (valid[g] && $stable(slots[g])));
    end

endmodule

// File: rtl/wpb_match.sv
module wpb_match
    import wpb_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  wpb_entry_t [DEPTH-1:0] slots,
    input  logic       [DEPTH-1:0] valid,
    input  logic       [PTR_W-1:0] rd_ptr,
    input  logic                   look,
    input  logic [ADDR_W-1:0]      look_addr,
    output logic                   hit,
    output logic [DATA_W-1:0]      data
);

    logic [DEPTH-1:0] eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = valid[g] && (slots[g].addr == look_addr);
    end

    // walk oldest to youngest so the youngest matching slot wins
    always_comb begin
        logic [PTR_W-1:0] s;
        hit  = 1'b0;
        data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            s = PTR_W'(wpb_wrap(int'(rd_ptr), i, DEPTH));
            if (eq[s]) begin
                hit  = look;
                data = slots[s].data;
            end
        end
    end

    always_comb begin
        if (hit) a_hit_needs_entry_r5: assert (|eq);
        if (look && (eq == '0)) a_no_entry_miss_r7: assert (!hit);
    end

endmodule

// File: rtl/wr_post_buffer.sv
module wr_post_buffer
    import wpb_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr_valid,
    input  logic [ADDR_W-1:0] cpu_wr_addr,
    input  logic [DATA_W-1:0] cpu_wr_data,
    output logic              cpu_wr_full,
    input  logic              cpu_rd_valid,
    input  logic [ADDR_W-1:0] cpu_rd_addr,
    output logic              rd_fwd_hit,
    output logic [DATA_W-1:0] rd_fwd_data,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic                   push, pop, full, empty;
    logic [PTR_W-1:0]       wr_ptr, rd_ptr;
    logic [CNT_W-1:0]       count;
    wpb_entry_t             new_entry;
    wpb_entry_t [DEPTH-1:0] slots;
    logic [DEPTH-1:0]       valid;
    logic                   hit;

    assign push      = cpu_wr_valid && !full;
    assign pop       = !empty && mem_wr_ack;
    assign new_entry = '{addr: cpu_wr_addr, data: cpu_wr_data};

    wpb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count),
        .full(full), .empty(empty)
    );

    wpb_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .push(push), .wr_ptr(wr_ptr),
        .wr_entry(new_entry), .pop(pop), .rd_ptr(rd_ptr),
        .slots(slots), .valid(valid)
    );

    wpb_match #(.DEPTH(DEPTH)) u_match (
        .slots(slots), .valid(valid), .rd_ptr(rd_ptr),
        .look(cpu_rd_valid), .look_addr(cpu_rd_addr),
        .hit(hit), .data(rd_fwd_data)
    );

    assign cpu_wr_full = full;
    assign rd_fwd_hit  = hit;
    assign mem_rd_req  = cpu_rd_valid && !hit;
    assign mem_rd_addr = cpu_rd_addr;
    assign mem_wr_req  = !empty;
    assign mem_wr_addr = slots[rd_ptr].addr;
    assign mem_wr_data = slots[rd_ptr].data;

    p_valid_tracks_count_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(valid) == int'(count));

    p_offer_held_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_req && !mem_wr_ack) |=>
            (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    p_full_drops_store_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_full && !mem_wr_ack) |=> cpu_wr_full);

    p_read_routed_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_rd_valid |-> $onehot({rd_fwd_hit, mem_rd_req}));

    p_empty_miss_r8: assert property (@(posedge clk) disable iff (rst)
        (!mem_wr_req && cpu_rd_valid) |-> mem_rd_req);

endmodule

// File: tb/test_wr_post_buffer.sv
`timescale 1ns/1ps
module test_wr_post_buffer;
    import wpb_pkg::*;

    localparam int DEPTH = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              cpu_wr_valid, cpu_rd_valid, mem_wr_ack;
    logic [ADDR_W-1:0] cpu_wr_addr, cpu_rd_addr;
    logic [DATA_W-1:0] cpu_wr_data;
    logic              cpu_wr_full, rd_fwd_hit, mem_rd_req, mem_wr_req;
    logic [ADDR_W-1:0] mem_rd_addr, mem_wr_addr;
    logic [DATA_W-1:0] rd_fwd_data, mem_wr_data;

    int checks = 0;
    int failures = 0;

    logic [ADDR_W-1:0] q_addr [$];
    logic [DATA_W-1:0] q_data [$];

    always #5 clk = ~clk;

    wr_post_buffer #(.DEPTH(DEPTH)) i_wr_post_buffer (
        .clk(clk), .rst(rst),
        .cpu_wr_valid(cpu_wr_valid), .cpu_wr_addr(cpu_wr_addr),
        .cpu_wr_data(cpu_wr_data), .cpu_wr_full(cpu_wr_full),
        .cpu_rd_valid(cpu_rd_valid), .cpu_rd_addr(cpu_rd_addr),
        .rd_fwd_hit(rd_fwd_hit), .rd_fwd_data(rd_fwd_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int match_count(input logic [ADDR_W-1:0] a);
        int n = 0;
        foreach (q_addr[i]) if (q_addr[i] == a) n++;
        return n;
    endfunction

    function automatic logic [DATA_W-1:0] newest_data(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] d = '0;
        foreach (q_addr[i]) if (q_addr[i] == a) d = q_data[i];
        return d;
    endfunction

    // drive one cycle of stimulus at the falling edge, check, update model
    task automatic step(input bit wv, input logic [ADDR_W-1:0] wa,
                        input logic [DATA_W-1:0] wd, input bit rv,
                        input logic [ADDR_W-1:0] ra, input bit ack);
        int  n;
        bit  do_push, do_pop;
        cpu_wr_valid = wv; cpu_wr_addr = wa; cpu_wr_data = wd;
        cpu_rd_valid = rv; cpu_rd_addr = ra; mem_wr_ack = ack;
        #1;
        n = q_addr.size();
        chk(cpu_wr_full == (n == DEPTH), "R2", "full flag",
            64'(cpu_wr_full), 64'(n == DEPTH));
        chk(mem_wr_req == (n != 0), "R3", "mem_wr_req",
            64'(mem_wr_req), 64'(n != 0));
        if (n != 0) begin
            chk(mem_wr_addr == q_addr[0], "R3", "oldest addr",
                64'(mem_wr_addr), 64'(q_addr[0]));
            chk(mem_wr_data == q_data[0], "R3", "oldest data",
                64'(mem_wr_data), 64'(q_data[0]));
        end
        if (rv) begin
            if (match_count(ra) != 0) begin
                chk(rd_fwd_hit && !mem_rd_req, "R5", "hit routing",
                    {62'd0, rd_fwd_hit, mem_rd_req}, 64'h2);
                if (match_count(ra) > 1)
                    chk(rd_fwd_data == newest_data(ra), "R6", "newest data",
                        64'(rd_fwd_data), 64'(newest_data(ra)));
                else
                    chk(rd_fwd_data == newest_data(ra), "R5", "forward data",
                        64'(rd_fwd_data), 64'(newest_data(ra)));
            end else begin
                chk(!rd_fwd_hit && mem_rd_req && mem_rd_addr == ra, "R7",
                    "bypass to memory", {47'd0, rd_fwd_hit, mem_rd_req, mem_rd_addr},
                    {48'h1, ra});
            end
        end
        do_push = wv && (n < DEPTH);
        do_pop  = ack && (n > 0);
        if (do_pop)  begin void'(q_addr.pop_front()); void'(q_data.pop_front()); end
        if (do_push) begin q_addr.push_back(wa); q_data.push_back(wd); end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, '0, '0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        cpu_wr_valid = 0; cpu_rd_valid = 0; mem_wr_ack = 0;
        cpu_wr_addr = '0; cpu_wr_data = '0; cpu_rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(!cpu_wr_full, "R1", "full after reset", 64'(cpu_wr_full), 64'd0);
        chk(!mem_wr_req, "R1", "mem_wr_req after reset", 64'(mem_wr_req), 64'd0);
        @(negedge clk);

        // R8: load from empty queue
        step(1'b0, '0, '0, 1'b1, 16'h0003, 1'b0);
        chk(!rd_fwd_hit, "R8", "empty queue hit", 64'(rd_fwd_hit), 64'd0);

        // R2: fill, then offer one more while full
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, ADDR_W'(16'h0010 + i), DATA_W'(32'hA000 + i), 1'b0, '0, 1'b0);
        chk(cpu_wr_full, "R2", "full after DEPTH stores", 64'(cpu_wr_full), 64'd1);
        step(1'b1, 16'h0077, 32'hDEAD, 1'b0, '0, 1'b0);
        // R3: drain in order; dropped store must not appear
        for (int i = 0; i < DEPTH; i++) begin
            chk(mem_wr_addr == ADDR_W'(16'h0010 + i), "R2", "drain order after drop",
                64'(mem_wr_addr), 64'(16'h0010 + i));
            step(1'b0, '0, '0, 1'b0, '0, 1'b1);
        end
        chk(!mem_wr_req, "R2", "dropped store absent", 64'(mem_wr_req), 64'd0);

        // R6: same address written twice
        step(1'b1, 16'h0005, 32'h1111, 1'b0, '0, 1'b0);
        step(1'b1, 16'h0005, 32'h2222, 1'b0, '0, 1'b0);
        step(1'b0, '0, '0, 1'b1, 16'h0005, 1'b0);
        chk(rd_fwd_data == 32'h2222, "R6", "newest of two", 64'(rd_fwd_data), 64'h2222);

        // R4: store and drain together keep occupancy
        step(1'b1, 16'h0006, 32'h3333, 1'b0, '0, 1'b1);
        chk(mem_wr_req && mem_wr_addr == 16'h0005 && mem_wr_data == 32'h2222, "R4",
            "after store+drain", 64'(mem_wr_data), 64'h2222);

        // R9: drain everything, then load a drained address
        step(1'b0, '0, '0, 1'b0, '0, 1'b1);
        step(1'b0, '0, '0, 1'b0, '0, 1'b1);
        step(1'b0, '0, '0, 1'b1, 16'h0006, 1'b0);
        chk(!rd_fwd_hit && mem_rd_req, "R9", "drained address misses",
            {62'd0, rd_fwd_hit, mem_rd_req}, 64'h1);
        idle();

        // random traffic over a small address set
        for (int c = 0; c < 3000; c++) begin
            step(($urandom % 3) != 0, ADDR_W'($urandom % 8), DATA_W'($urandom),
                 ($urandom % 2) != 0, ADDR_W'($urandom % 8),
                 ($urandom % 4) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule